// File: doc/BRIEF.md
# Display Power-Up Reset Sequencer

This block sits on the host side of a small parallel-bus display and brings the display up after power-on or when software asks for a restart. It holds the display's active-low reset line low for a programmed minimum width. After releasing it, the block waits a first interval before it lets any command traffic through. It waits a second, longer interval before it presents the sleep-exit command to the bus master. Once the bus master accepts that command, the block reports that the display is ready.

A gate output tells the bus master when commands may be sent. Once the display is ready, frame writes can be aligned to the display's tearing-effect output. That input is brought into the clock domain through a two-flop synchroniser. Each accepted frame request turns into a single-cycle frame-start pulse on the next rising edge of the tearing-effect signal. When the tearing-effect signal is not used, the pulse is issued at once.

All intervals are counted in clock cycles and set by parameters. A bench can therefore shrink them, while silicon uses values that cover 10 µs of reset, 5 ms before commands and 120 ms before sleep-exit. `SLP_CYC` must be larger than `CMD_CYC`.

Top module: `disp_pwrup_seq`

## Requirements
- R1: While rst_ni is low, disp_rst_no, cmd_ok_o, cmd_valid_o, ready_o and frame_start_o are all 0.
- R2: After rst_ni is released, and after every accepted restart, disp_rst_no is low for exactly RST_CYC clock cycles and then goes high.
- R3: cmd_ok_o is 0 while disp_rst_no is low. It first goes high exactly CMD_CYC cycles after the first cycle in which disp_rst_no is high, and stays high until the next restart.
- R4: cmd_valid_o first goes high exactly SLP_CYC cycles after the first cycle in which disp_rst_no is high. While it is high, cmd_code_o carries SLP_CODE (default 8'h11).
- R5: cmd_valid_o stays high while cmd_ack_i is low. In the cycle after cmd_ack_i is sampled high, cmd_valid_o is 0 and ready_o is 1.
- R6: start_i sampled high while ready_o is 1 starts a new reset pulse; start_i is ignored during any other phase, so the phase timings of R2 to R4 are unchanged.
- R7: With te_en_i = 0 and ready_o = 1, frame_start_o is 1 in the same cycle as frame_req_i.
- R8: With te_en_i = 1, a frame request is held pending. frame_start_o pulses for one cycle, two clock cycles after te_i rises, and gives exactly one pulse per request; te_i edges with no pending request give no pulse.
- R9: frame_start_o is never 1 while ready_o is 0, and frame requests made before ready_o rises are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset; its release starts the power-on sequence |
| start_i | input | 1 | Restart request, honoured only when ready |
| cmd_ack_i | input | 1 | Bus master accepted the sleep-exit command |
| te_en_i | input | 1 | 1: align frame starts to the tearing-effect input |
| te_i | input | 1 | Tearing-effect signal from the display, asynchronous |
| frame_req_i | input | 1 | Request to start a frame write |
| disp_rst_no | output | 1 | Active-low reset to the display, registered |
| cmd_ok_o | output | 1 | Commands may be sent to the display |
| cmd_valid_o | output | 1 | Sleep-exit command presented to the bus master |
| cmd_code_o | output | 8 | Command byte for cmd_valid_o |
| ready_o | output | 1 | Display brought up |
| frame_start_o | output | 1 | Single-cycle frame-write start |

## Verification
The timing assertions measure every interval from the display reset line itself. They assume the clock keeps running through the whole sequence, so the counts in cycles equal time. They also take te_i to be a level that changes no faster than the two-flop synchroniser can follow, and take cmd_ack_i to be raised only while the command is offered. The stimulus drives every input half a cycle away from the capturing edge. It raises the acknowledge only after cmd_valid_o is seen, and holds te_i steady for several cycles between edges. Restart and the acknowledge delay are swept together so that each bring-up is timed again against the same fixed counts.

// File: rtl/disp_seq_pkg.sv
package disp_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_RST_LOW   = 3'd1,
    ST_WAIT_CMD  = 3'd2,
    ST_WAIT_SLP  = 3'd3,
    ST_SEND_SLP  = 3'd4,
    ST_READY     = 3'd5
  } seq_state_e;
endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          zero_o
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import disp_seq_pkg::*;
#(
  parameter int unsigned CW      = 8,
  parameter int unsigned RST_CYC = 4,
  parameter int unsigned CMD_CYC = 10,
  parameter int unsigned SLP_CYC = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          cmd_ack_i,
  input  logic          tmr_zero_i,
  output logic          tmr_load_o,
  output logic [CW-1:0] tmr_val_o,
  output logic          disp_rst_no,
  output logic          cmd_ok_o,
  output logic          cmd_valid_o,
  output logic          ready_o
);
  localparam logic [CW-1:0] RstLd = CW'(RST_CYC - 1);
  localparam logic [CW-1:0] CmdLd = CW'(CMD_CYC - 1);
  localparam logic [CW-1:0] SlpLd = CW'(SLP_CYC - CMD_CYC - 1);

  seq_state_e st_q, st_d;
  logic       rst_line_q;

  always_comb begin
    st_d       = st_q;
    tmr_load_o = 1'b0;
    tmr_val_o  = '0;
    unique case (st_q)
      ST_IDLE: begin
        st_d = ST_RST_LOW; tmr_load_o = 1'b1; tmr_val_o = RstLd;
      end
      ST_RST_LOW: if (tmr_zero_i) begin
        st_d = ST_WAIT_CMD; tmr_load_o = 1'b1; tmr_val_o = CmdLd;
      end
      ST_WAIT_CMD: if (tmr_zero_i) begin
        st_d = ST_WAIT_SLP; tmr_load_o = 1'b1; tmr_val_o = SlpLd;
      end
      ST_WAIT_SLP: if (tmr_zero_i) st_d = ST_SEND_SLP;
      ST_SEND_SLP: if (cmd_ack_i)  st_d = ST_READY;
      ST_READY: if (start_i) begin
        st_d = ST_RST_LOW; tmr_load_o = 1'b1; tmr_val_o = RstLd;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      rst_line_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      // registered so the pin never glitches on state decode
      rst_line_q <= !(st_d == ST_IDLE || st_d == ST_RST_LOW);
    end
  end

  assign disp_rst_no = rst_line_q;
  assign cmd_ok_o    = (st_q == ST_WAIT_SLP) || (st_q == ST_SEND_SLP) || (st_q == ST_READY);
  assign cmd_valid_o = (st_q == ST_SEND_SLP);
  assign ready_o     = (st_q == ST_READY);
endmodule

// File: rtl/frame_align.sv
module frame_align #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ready_i,
  input  logic te_en_i,
  input  logic te_i,
  input  logic req_i,
  output logic start_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   te_prev_q;
  logic                   pend_q;
  logic                   te_rise;
  logic                   want;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q    <= '0;
      te_prev_q <= 1'b0;
    end else begin
      sync_q    <= {sync_q[SYNC_STAGES-2:0], te_i};
      te_prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign te_rise = sync_q[SYNC_STAGES-1] && !te_prev_q;
  assign want    = ready_i && (pend_q || req_i);
  assign start_o = want && (!te_en_i || te_rise);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pend_q <= 1'b0;
    else if (!ready_i) pend_q <= 1'b0;
    else               pend_q <= want && !start_o;
  end
endmodule

// File: rtl/disp_pwrup_seq.sv
module disp_pwrup_seq #(
  parameter int unsigned RST_CYC  = 500,
  parameter int unsigned CMD_CYC  = 250_000,
  parameter int unsigned SLP_CYC  = 6_000_000,
  parameter logic [7:0]  SLP_CODE = 8'h11
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       cmd_ack_i,
  input  logic       te_en_i,
  input  logic       te_i,
  input  logic       frame_req_i,
  output logic       disp_rst_no,
  output logic       cmd_ok_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_code_o,
  output logic       ready_o,
  output logic       frame_start_o
);
  localparam int unsigned MaxCyc = (SLP_CYC > RST_CYC) ? SLP_CYC : RST_CYC;
  localparam int unsigned CW     = $clog2(MaxCyc + 1);

  logic          tmr_load, tmr_zero;
  logic [CW-1:0] tmr_val;

  seq_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni,
    .load_i(tmr_load), .load_val_i(tmr_val), .zero_o(tmr_zero)
  );

  seq_fsm #(
    .CW(CW), .RST_CYC(RST_CYC), .CMD_CYC(CMD_CYC), .SLP_CYC(SLP_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .start_i, .cmd_ack_i,
    .tmr_zero_i(tmr_zero), .tmr_load_o(tmr_load), .tmr_val_o(tmr_val),
    .disp_rst_no, .cmd_ok_o, .cmd_valid_o, .ready_o
  );

  frame_align #(.SYNC_STAGES(2)) u_frame (
    .clk_i, .rst_ni, .ready_i(ready_o), .te_en_i, .te_i,
    .req_i(frame_req_i), .start_o(frame_start_o)
  );

  assign cmd_code_o = cmd_valid_o ? SLP_CODE : 8'h00;
endmodule

// File: rtl/disp_pwrup_seq_chk.sv
module disp_pwrup_seq_chk #(
  parameter int unsigned RST_CYC = 500,
  parameter int unsigned CMD_CYC = 250_000,
  parameter int unsigned SLP_CYC = 6_000_000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic disp_rst_no,
  input logic cmd_ok_o,
  input logic cmd_valid_o,
  input logic ready_o,
  input logic frame_start_o
);
  localparam int unsigned Sat = 32'h7fff_ffff;
  int unsigned low_cnt, rel_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      low_cnt <= 0;
      rel_cnt <= 0;
    end else begin
      low_cnt <= disp_rst_no ? 0 : ((low_cnt < Sat) ? low_cnt + 1 : low_cnt);
      rel_cnt <= !disp_rst_no ? 0 : ((rel_cnt < Sat) ? rel_cnt + 1 : rel_cnt);
    end
  end

  // R2
  rst_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(disp_rst_no) |-> low_cnt >= RST_CYC);
  // R3
  gate_in_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !disp_rst_no |-> !cmd_ok_o);
  // R3
  gate_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ok_o |-> rel_cnt >= CMD_CYC);
  // R4
  slp_wait_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> (rel_cnt >= SLP_CYC) && cmd_ok_o);
  // R5
  valid_ready_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cmd_valid_o && ready_o));
  // R9
  frame_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_start_o |-> ready_o);
endmodule

bind disp_pwrup_seq disp_pwrup_seq_chk #(
  .RST_CYC(RST_CYC), .CMD_CYC(CMD_CYC), .SLP_CYC(SLP_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .disp_rst_no(disp_rst_no),
  .cmd_ok_o(cmd_ok_o), .cmd_valid_o(cmd_valid_o), .ready_o(ready_o),
  .frame_start_o(frame_start_o)
);

// File: tb/disp_pwrup_seq_tb.sv
module disp_pwrup_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int RST_CYC = 4;
  localparam int CMD_CYC = 10;
  localparam int SLP_CYC = 25;
  localparam logic [7:0] SLP_CODE = 8'h11;

  logic clk = 1'b0;
  logic rst_ni = 1'b0, start_i = 1'b0, cmd_ack_i = 1'b0;
  logic te_en_i = 1'b0, te_i = 1'b0, frame_req_i = 1'b0;
  logic disp_rst_no, cmd_ok_o, cmd_valid_o, ready_o, frame_start_o;
  logic [7:0] cmd_code_o;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  disp_pwrup_seq #(.RST_CYC(RST_CYC), .CMD_CYC(CMD_CYC), .SLP_CYC(SLP_CYC),
                   .SLP_CODE(SLP_CODE)) u_dut (
    .clk_i(clk), .rst_ni, .start_i, .cmd_ack_i, .te_en_i, .te_i, .frame_req_i,
    .disp_rst_no, .cmd_ok_o, .cmd_valid_o, .cmd_code_o, .ready_o, .frame_start_o);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(negedge clk); #1;
  endtask

  // full bring-up; noisy=1 toggles start_i, te_i and frame_req_i meanwhile
  task automatic bringup(input int ack_dly, input bit noisy);
    int low = 0, idx = 0, first_ok = -1, fs = 0;
    tick();
    if (!noisy) start_i = 1'b0;
    while (!disp_rst_no && low < 1000) begin
      if (cmd_ok_o) check(0, "R3 gate in reset", 1, 0);
      low++; tick();
    end
    check(low == RST_CYC, "R2 reset width", low, RST_CYC);
    while (!cmd_valid_o && idx < 1000) begin
      if (cmd_ok_o && first_ok < 0) first_ok = idx;
      if (frame_start_o) fs++;
      if (noisy) begin te_i = idx[1]; frame_req_i = 1'b1; te_en_i = idx[3]; end
      idx++; tick();
    end
    start_i = 1'b0; frame_req_i = 1'b0; te_i = 1'b0; te_en_i = 1'b0;
    check(first_ok == CMD_CYC, "R3 gate delay", first_ok, CMD_CYC);
    check(idx == SLP_CYC, "R4 sleep-exit delay", idx, SLP_CYC);
    check(cmd_code_o == SLP_CODE, "R4 command code", cmd_code_o, SLP_CODE);
    if (noisy) check(fs == 0, "R9 no frame start before ready", fs, 0);
    for (int i = 0; i < ack_dly; i++) begin
      tick();
      check(cmd_valid_o && !ready_o, "R5 hold without ack", cmd_valid_o, 1);
    end
    cmd_ack_i = 1'b1;
    tick();
    cmd_ack_i = 1'b0;
    check(ready_o && !cmd_valid_o, "R5 ready after ack", ready_o, 1);
    check(frame_start_o == 1'b0, "R9 dropped early requests", frame_start_o, 0);
  endtask

  initial begin
    repeat (CLK_PERIOD * 200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) tick();
    // R1
    check(!disp_rst_no && !cmd_ok_o && !cmd_valid_o && !ready_o && !frame_start_o,
          "R1 reset state", {disp_rst_no, cmd_ok_o, cmd_valid_o, ready_o}, 0);
    rst_ni = 1'b1;
    bringup(0, 1'b0);

    // R6 restart sweep over acknowledge delays, with ignored stimulus on odd runs
    for (int d = 0; d < 4; d++) begin
      start_i = 1'b1;
      bringup(d, d[0]);
    end

    // R7 frame start without tearing alignment
    te_en_i = 1'b0;
    tick();
    frame_req_i = 1'b1; #1;
    check(frame_start_o == 1'b1, "R7 immediate start", frame_start_o, 1);
    tick();
    frame_req_i = 1'b0; #1;
    check(frame_start_o == 1'b0, "R7 single pulse", frame_start_o, 0);

    // R8 aligned start: request waits for te rise, then fires two cycles after
    te_en_i = 1'b1;
    tick();
    frame_req_i = 1'b1; #1;
    check(frame_start_o == 1'b0, "R8 waits for te", frame_start_o, 1);
    for (int i = 0; i < 4; i++) begin
      tick(); frame_req_i = 1'b0;
      check(frame_start_o == 1'b0, "R8 pending no pulse", frame_start_o, 0);
    end
    te_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      check(frame_start_o == (k == 2), "R8 te alignment", frame_start_o, (k == 2));
    end
    te_i = 1'b0;
    repeat (4) tick();
    te_i = 1'b1;
    for (int k = 1; k <= 5; k++) begin
      tick();
      check(frame_start_o == 1'b0, "R8 no request no pulse", frame_start_o, 0);
    end
    te_i = 1'b0;

    // R6 start_i while ready restarts, outputs drop
    start_i = 1'b1;
    tick();
    start_i = 1'b0;
    check(!ready_o && !disp_rst_no && !cmd_ok_o, "R6 restart from ready", ready_o, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule